// File: doc/BRIEF.md
# Start-Bit Framed Serial Control Port

This block is the register front end of a mixed-signal radio controller. A host drives a four-wire serial link: an active-low select, a serial clock, a data input and a data output. Every transaction is a 16-bit frame. The frame opens with a start bit, which is the first 1 sampled after select goes low. A 7-bit command follows: a 3-bit address, two power-mode bits, a shutdown bit and a load bit. The last part is an 8-bit data byte, sent most significant bit first.

Writes go into shadow (input) registers. The live settings seen by the converters, selectors and shutdown pin change only when a frame carries the load bit. A load then copies every shadow register to its active register in the same clock cycle. A read frame shifts out an 8-bit conversion result during its data phase.

The serial signals are sampled by the block's own system clock, which must run at least eight times faster than the serial clock. Edges of the serial clock are found by comparing each sample with the one before.

Top module: `sp_ctrl_port`

## Requirements
- R1: After a synchronous active-low reset the following are all 0: every converter code, both selection bits, the 2-bit class, the power mode {rx_en,tx_en}, sdg and the four enables, and sdo.
- R2: Data input is sampled on serial-clock falling edges while select is low. Zeros before the first 1 are ignored, and that 1 is the start bit. The next 15 samples are, in order, address A2..A0, rx, tx, sd, ld, then data D7..D0.
- R3: Address decode acts on the data byte as follows:
  - 000 puts D[5:0] into tune_code.
  - 001 puts D7 into fwd_sel and D[6:0] into upgain_code.
  - 010 puts D7 into chan_direct and D[6:0] into modgain_code.
  - 011 puts D[7:6] into pwr_class and D[5:0] into bias_code.
- R4: A complete frame with ld=0 leaves every active output unchanged. Its values stay in the shadow registers.
- R5: A complete frame with ld=1 copies all shadow registers to the outputs together, including the rx, tx and sd bits of this frame. The copy happens right after the last data bit and applies to read frames too.
- R6: Addresses 100, 101 and 110 change no code, selection or class shadow register. Their rx, tx and sd bits are still stored, and their ld bit is still honoured.
- R7: Address 111 is a read. On each of the eight serial-clock rising edges that follow the ld bit, sdo presents the next bit of adc_code, MSB first. The frame's data bits are ignored.
- R8: sdo_oe is 1 exactly while cs_n is low, and sdo is 0 while cs_n is high.
- R9: sdg equals the active sd bit. bias_en requires sd=1.
- R10: The enables follow the active mode {rx_en,tx_en}:
  - 00 (off) turns every enable off.
  - 01 (transmit) turns all four on, with bias gated by sd.
  - 10 (receive) turns on tune and modgain only.
  - 11 (standby) turns on tune and bias, with bias gated by sd.
- R11: If cs_n rises before the 16th bit, the partial frame is dropped. No shadow or active register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| adc_code | input | 8 | Conversion result to return on reads |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| tune_code | output | 6 | Active tuning converter code |
| fwd_sel | output | 1 | Forward (1) or reverse (0) sense select |
| upgain_code | output | 7 | Active up/down-converter gain code |
| chan_direct | output | 1 | Converter input: 1 direct, 0 peak-held |
| modgain_code | output | 7 | Active modulator gain code |
| pwr_class | output | 2 | Active power class |
| bias_code | output | 6 | Active bias converter code |
| rx_en | output | 1 | Active receive mode bit |
| tx_en | output | 1 | Active transmit mode bit |
| sdg | output | 1 | Shutdown logic output (low = external bias off) |
| tune_en | output | 1 | Tuning converter enable |
| upgain_en | output | 1 | Up/down gain converter enable |
| modgain_en | output | 1 | Modulator gain converter enable |
| bias_en | output | 1 | Bias converter enable |

## Verification
A bit counter that is one off shows up at once as a shifted field: a code lands in the wrong output, or takes the wrong neighbouring bit. This becomes visible on the first loading frame after the fault. A shadow register that wrongly follows every frame is caught when an ld=0 frame changes an output a few clocks after select rises. A stuck start-bit detector either misses a frame entirely or treats a leading zero as data, and that corrupts the first observed load. A read shift register that is off by one edge shows the wrong bit on the first sampled data-phase clock.

// File: rtl/sp_ctrl_pkg.sv
// Package: shared widths, address codes and the settings record for the
// serial control port. Assumes a fixed 7-bit command layout.
package sp_ctrl_pkg;
    localparam int CMD_W   = 7;
    localparam int DATA_W  = 8;
    localparam int TUNE_W  = 6;
    localparam int GAIN_W  = 7;
    localparam int BIAS_W  = 6;
    localparam int CLASS_W = 2;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_TUNE = 3'b000;
    localparam logic [ADDR_W-1:0] ADDR_UPG  = 3'b001;
    localparam logic [ADDR_W-1:0] ADDR_MODG = 3'b010;
    localparam logic [ADDR_W-1:0] ADDR_BIAS = 3'b011;
    localparam logic [ADDR_W-1:0] ADDR_READ = 3'b111;

    typedef struct packed {
        logic [TUNE_W-1:0]  tune;
        logic               fwd;
        logic [GAIN_W-1:0]  upg;
        logic               chan;
        logic [GAIN_W-1:0]  modg;
        logic [CLASS_W-1:0] cls;
        logic [BIAS_W-1:0]  bias;
        logic               rx;
        logic               tx;
        logic               sd;
    } settings_t;
endpackage

// File: rtl/sp_frame_rx.sv
// Frame receiver: finds the start bit, counts the 15 following samples and
// presents the command (after bit 7) and the data byte (after bit 15) as
// one-cycle strobes. Assumes sclk_fall is a one-cycle pulse in the clk domain.
module sp_frame_rx
    import sp_ctrl_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk_fall,
    input  logic          sdi,
    output logic          busy,
    output logic          cmd_stb,
    output logic [CW-1:0] cmd_word,
    output logic          done_stb,
    output logic [DW-1:0] data_word
);
    localparam int BITS  = CW + DW;
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CW - 1);
    localparam logic [CNT_W-1:0] ALL_LAST = CNT_W'(BITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [DW-2:0]    shreg;

    // Start detection, bit counting and field capture on falling sclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            cmd_word  <= '0;
            data_word <= '0;
            cmd_stb   <= 1'b0;
            done_stb  <= 1'b0;
        end else begin
            cmd_stb  <= 1'b0;
            done_stb <= 1'b0;
            if (cs_n) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (sclk_fall) begin
                if (!busy) begin
                    if (sdi) begin
                        busy      <= 1'b1;
                        cnt       <= '0;
                        shreg     <= '0;
                        cmd_word  <= '0;
                        data_word <= '0;
                    end
                end else begin
                    shreg <= {shreg[DW-3:0], sdi};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CMD_LAST) begin
                        cmd_word <= {shreg[CW-2:0], sdi};
                        cmd_stb  <= 1'b1;
                    end
                    if (cnt == ALL_LAST) begin
                        data_word <= {shreg[DW-2:0], sdi};
                        done_stb  <= 1'b1;
                        busy      <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sp_setting_regs.sv
// Double-buffered settings: a completed frame updates the shadow copy from
// its address and command bits; a set load bit copies the resulting shadow
// into the active copy in the same cycle. Assumes done_stb is one cycle wide.
module sp_setting_regs
    import sp_ctrl_pkg::*;
#(
    parameter int CW = CMD_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_stb,
    input  logic [CW-1:0] cmd_word,
    input  logic [DW-1:0] data_word,
    output settings_t     active
);
    settings_t           shadow, shadow_nxt;
    logic [ADDR_W-1:0]   addr;
    logic                ld;

    assign addr = cmd_word[CW-1 -: ADDR_W];
    assign ld   = cmd_word[0];

    // Next shadow value from the address decode and the mode bits.
    always_comb begin
        shadow_nxt    = shadow;
        shadow_nxt.rx = cmd_word[3];
        shadow_nxt.tx = cmd_word[2];
        shadow_nxt.sd = cmd_word[1];
        case (addr)
            ADDR_TUNE: shadow_nxt.tune = data_word[TUNE_W-1:0];
            ADDR_UPG: begin
                shadow_nxt.fwd = data_word[DW-1];
                shadow_nxt.upg = data_word[GAIN_W-1:0];
            end
            ADDR_MODG: begin
                shadow_nxt.chan = data_word[DW-1];
                shadow_nxt.modg = data_word[GAIN_W-1:0];
            end
            ADDR_BIAS: begin
                shadow_nxt.cls  = data_word[DW-1 -: CLASS_W];
                shadow_nxt.bias = data_word[BIAS_W-1:0];
            end
            default: ;
        endcase
    end

    // Shadow update on every full frame, active copy only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else if (done_stb) begin
            shadow <= shadow_nxt;
            if (ld) active <= shadow_nxt;
        end
    end
endmodule

// File: rtl/sp_readout.sv
// Read shifter: captures the conversion result when a read command is
// decoded and presents one bit per rising sclk, MSB first, eight times.
// Assumes cmd_stb and sclk_rise never coincide.
module sp_readout
    import sp_ctrl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk_rise,
    input  logic          rd_start,
    input  logic [DW-1:0] adc_code,
    output logic          sdo_q
);
    localparam int LEFT_W = $clog2(DW + 1);

    logic [DW-1:0]     sh;
    logic [LEFT_W-1:0] left;

    // Load on read decode, shift out on rising sclk, clear when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            left  <= '0;
            sdo_q <= 1'b0;
        end else if (cs_n) begin
            left  <= '0;
            sdo_q <= 1'b0;
        end else if (rd_start) begin
            sh   <= adc_code;
            left <= LEFT_W'(DW);
        end else if (sclk_rise && left != '0) begin
            sdo_q <= sh[DW-1];
            sh    <= {sh[DW-2:0], 1'b0};
            left  <= left - 1'b1;
        end
    end
endmodule

// File: rtl/sp_ctrl_port.sv
// Top of the serial control port: edge detection of sclk in the clk domain,
// frame receiver, double-buffered settings, read shifter and the per-mode
// converter enables. Assumes cs_n, sclk, sdi are synchronous to clk and that
// each sclk level lasts at least two clk cycles.
module sp_ctrl_port
    import sp_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic [DATA_W-1:0]  adc_code,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [TUNE_W-1:0]  tune_code,
    output logic               fwd_sel,
    output logic [GAIN_W-1:0]  upgain_code,
    output logic               chan_direct,
    output logic [GAIN_W-1:0]  modgain_code,
    output logic [CLASS_W-1:0] pwr_class,
    output logic [BIAS_W-1:0]  bias_code,
    output logic               rx_en,
    output logic               tx_en,
    output logic               sdg,
    output logic               tune_en,
    output logic               upgain_en,
    output logic               modgain_en,
    output logic               bias_en
);
    logic              sclk_q, sclk_fall, sclk_rise;
    logic              busy, cmd_stb, done_stb, sdo_q, rd_start;
    logic [CMD_W-1:0]  cmd_word;
    logic [DATA_W-1:0] data_word;
    settings_t         act;

    // Previous sclk level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end
    assign sclk_fall = sclk_q & ~sclk;
    assign sclk_rise = ~sclk_q & sclk;
    assign rd_start  = cmd_stb && (cmd_word[CMD_W-1 -: ADDR_W] == ADDR_READ);

    sp_frame_rx #(.CW(CMD_W), .DW(DATA_W)) u_rx (
        .clk, .rst_n, .cs_n, .sclk_fall, .sdi, .busy,
        .cmd_stb, .cmd_word, .done_stb, .data_word
    );

    sp_setting_regs #(.CW(CMD_W), .DW(DATA_W)) u_regs (
        .clk, .rst_n, .done_stb, .cmd_word, .data_word, .active(act)
    );

    sp_readout #(.DW(DATA_W)) u_rd (
        .clk, .rst_n, .cs_n, .sclk_rise, .rd_start, .adc_code, .sdo_q
    );

    assign sdo          = sdo_q & ~cs_n;
    assign sdo_oe       = ~cs_n;
    assign tune_code    = act.tune;
    assign fwd_sel      = act.fwd;
    assign upgain_code  = act.upg;
    assign chan_direct  = act.chan;
    assign modgain_code = act.modg;
    assign pwr_class    = act.cls;
    assign bias_code    = act.bias;
    assign rx_en        = act.rx;
    assign tx_en        = act.tx;
    assign sdg          = act.sd;

    // Converter enables from the active power mode and shutdown bit.
    always_comb begin
        tune_en    = 1'b0;
        upgain_en  = 1'b0;
        modgain_en = 1'b0;
        bias_en    = 1'b0;
        case ({act.rx, act.tx})
            2'b01: begin
                tune_en = 1'b1; upgain_en = 1'b1; modgain_en = 1'b1;
                bias_en = act.sd;
            end
            2'b10: begin
                tune_en = 1'b1; modgain_en = 1'b1;
            end
            2'b11: begin
                tune_en = 1'b1; bias_en = act.sd;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sp_ctrl_port_chk.sv
// Checker for the serial control port, attached by bind. Observes ports and
// the strobes and state passed between the submodules.
module sp_ctrl_port_chk
    import sp_ctrl_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      sdo,
    input logic      busy,
    input logic      load_evt,
    input settings_t act,
    input logic      sdg,
    input logic      tune_en,
    input logic      upgain_en,
    input logic      modgain_en,
    input logic      bias_en
);
    // R4
    hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_evt |=> $stable(act));

    // R11
    deselect_drops_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !busy);

    // R8
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo |-> !cs_n);

    // R9
    bias_needs_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_en |-> sdg);

    // R10
    transmit_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upgain_en |-> (tune_en && modgain_en));
endmodule

bind sp_ctrl_port sp_ctrl_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .busy(busy),
    .load_evt(done_stb & cmd_word[0]), .act(act), .sdg(sdg),
    .tune_en(tune_en), .upgain_en(upgain_en), .modgain_en(modgain_en),
    .bias_en(bias_en)
);

// File: tb/sp_ctrl_port_test.sv
module sp_ctrl_port_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [7:0] adc_code = 8'h00;
    logic       sdo, sdo_oe, fwd_sel, chan_direct, rx_en, tx_en, sdg;
    logic       tune_en, upgain_en, modgain_en, bias_en;
    logic [5:0] tune_code, bias_code;
    logic [6:0] upgain_code, modgain_code;
    logic [1:0] pwr_class;

    sp_ctrl_port uut (.*);

    typedef struct { logic [36:0] v; string tag; } exp_t;
    exp_t sb[$];
    int   n_run = 0, n_fail = 0;
    bit   ended = 1'b0;

    // bench model: shadow (s_) and active (a_) copies
    logic [5:0] s_tune, a_tune, s_bias, a_bias;
    logic [6:0] s_upg, a_upg, s_mod, a_mod;
    logic [1:0] s_cls, a_cls;
    logic s_fwd, a_fwd, s_chan, a_chan, s_rx, a_rx, s_tx, a_tx, s_sd, a_sd;

    function automatic logic [36:0] dut_vec();
        return {tune_code, fwd_sel, upgain_code, chan_direct, modgain_code,
                pwr_class, bias_code, rx_en, tx_en, sdg,
                tune_en, upgain_en, modgain_en, bias_en};
    endfunction

    function automatic logic [36:0] exp_vec();
        logic [3:0] en;
        case ({a_rx, a_tx})
            2'b00: en = 4'b0000;
            2'b01: en = {3'b111, a_sd};
            2'b10: en = 4'b1010;
            default: en = {3'b100, a_sd};
        endcase
        return {a_tune, a_fwd, a_upg, a_chan, a_mod, a_cls, a_bias,
                a_rx, a_tx, a_sd, en};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare queued expectations against the ports
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, 64'(dut_vec()), 64'(e.v));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_out(input logic b, output logic got);
        sclk = 1'b1; tick(2);
        sdi  = b;    tick(2);
        got  = sdo;
        sclk = 1'b0; tick(4);
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.v = exp_vec(); e.tag = tag;
        sb.push_back(e);
        tick(3);
    endtask

    task automatic frame(input logic [2:0] a, input logic rx, input logic tx,
                         input logic sd, input logic ld, input logic [7:0] d,
                         input int lead, input int nbits, input string tag);
        logic [15:0] w;
        logic got;
        w = {1'b1, a, rx, tx, sd, ld, d};
        cs_n = 1'b0; tick(2);
        chk({tag, " R8 oe low-select"}, 64'(sdo_oe), 64'd1);
        for (int i = 0; i < lead; i++) bit_out(1'b0, got);
        for (int i = 15; i >= 16 - nbits; i--) begin
            bit_out(w[i], got);
            if (a == 3'b111 && i <= 7 && nbits == 16)
                chk({tag, " R7 sdo bit"}, 64'(got), 64'(adc_code[i]));
        end
        sdi = 1'b0; tick(2);
        cs_n = 1'b1; tick(3);
        chk({tag, " R8 deselected"}, 64'({sdo_oe, sdo}), 64'd0);
        if (nbits == 16) begin
            s_rx = rx; s_tx = tx; s_sd = sd;
            case (a)
                3'b000: s_tune = d[5:0];
                3'b001: begin s_fwd = d[7]; s_upg = d[6:0]; end
                3'b010: begin s_chan = d[7]; s_mod = d[6:0]; end
                3'b011: begin s_cls = d[7:6]; s_bias = d[5:0]; end
                default: ;
            endcase
            if (ld) begin
                a_tune = s_tune; a_fwd = s_fwd; a_upg = s_upg; a_chan = s_chan;
                a_mod = s_mod; a_cls = s_cls; a_bias = s_bias;
                a_rx = s_rx; a_tx = s_tx; a_sd = s_sd;
            end
        end
        push(tag);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        {s_tune, a_tune, s_bias, a_bias, s_upg, a_upg, s_mod, a_mod} = '0;
        {s_cls, a_cls, s_fwd, a_fwd, s_chan, a_chan} = '0;
        {s_rx, a_rx, s_tx, a_tx, s_sd, a_sd} = '0;
        tick(4);
        rst_n = 1'b1; tick(2);
        chk("R1 sdo after reset", 64'({sdo, sdo_oe}), 64'd0);
        push("R1 reset state");
        // shadow-only writes
        frame(3'b000, 0, 1, 1, 0, 8'h2A, 0, 16, "R4 tune no load");
        frame(3'b001, 0, 1, 1, 0, 8'hC5, 0, 16, "R4 upgain no load");
        frame(3'b010, 0, 1, 1, 0, 8'h9B, 0, 16, "R4 modgain no load");
        // loading frame with leading zeros: all fields appear together
        frame(3'b011, 0, 1, 1, 1, 8'hB7, 3, 16, "R5 R3 R2 load transmit");
        frame(3'b101, 1, 0, 1, 1, 8'hFF, 0, 16, "R6 R10 reserved receive");
        frame(3'b110, 1, 1, 0, 1, 8'h00, 1, 16, "R9 R10 standby sd0");
        frame(3'b100, 1, 1, 1, 1, 8'h3C, 0, 16, "R10 R6 standby sd1");
        // aborted frames
        frame(3'b000, 0, 1, 0, 1, 8'h11, 0, 10, "R11 abort 10 bits");
        frame(3'b011, 0, 0, 0, 1, 8'h40, 2, 15, "R11 abort 15 bits");
        frame(3'b001, 1, 1, 1, 0, 8'h00, 0, 16, "R11 shadow kept");
        frame(3'b101, 1, 1, 1, 1, 8'h00, 0, 16, "R11 R6 reload");
        // reads
        adc_code = 8'h96;
        frame(3'b111, 0, 0, 1, 1, 8'h5A, 0, 16, "R7 R5 read load off");
        adc_code = 8'h01;
        frame(3'b111, 0, 1, 1, 0, 8'hFF, 4, 16, "R7 read no load");
        frame(3'b000, 0, 1, 1, 1, 8'hFF, 5, 16, "R3 R2 tune full");
        frame(3'b010, 1, 0, 1, 1, 8'h80, 0, 16, "R3 chan direct");
        tick(10);
        finish_run();
    end
endmodule